// File: doc/BRIEF.md
# Auto-Increment Buffer Window Port

This block gives a host byte access to an on-chip SRAM through one data window. It keeps two pointers: one for reads and one for writes. The host can load either pointer directly. Each read or write through the window uses its own pointer and then moves that pointer forward.

A pointer returns to address zero at one of two points. The first is the byte just below a programmable receive-area start. The second is the last implemented byte. Because of this, the space below the receive area works as a circular buffer. A pointer can still be loaded with any address, including one inside the receive area.

The SRAM is modelled inside the block as a synchronous single-port array. Parameter `MEM_LAST` sets the last implemented byte. The full-size build uses `MEM_LAST = 0x5FFF`, which gives 24 KB. The default value is smaller, which keeps a standalone elaboration light.

Top module: `bufwin_port`

## Requirements
- R1: After reset, `rptr` and `wptr` are both 0x0000 and `rd_byte` is 0x00.
- R2: A pulse on `ld_rptr` (or `ld_wptr`) stores `ptr_val` into the read (or write) pointer. The new value is visible on `rptr` (or `wptr`) at the next clock edge. Any 15-bit address is accepted, including addresses at or above the receive start.
- R3: A read (`rd_stb` high, `wr_stb` low) places the SRAM byte at the current `rptr` on `rd_byte` one clock later and advances `rptr`. `wptr` does not change. `rd_byte` holds its value in every cycle without a read.
- R4: A write (`wr_stb` high) stores `wr_byte` at the current `wptr` and advances `wptr`. `rptr` does not change.
- R5: In the case with no wrap, an advance adds exactly 1 to the pointer.
- R6: If the pointer equals the effective receive start minus 1, it advances to 0x0000. This check has priority over the end-of-memory check.
- R7: If the pointer equals `MEM_LAST` (0x5FFF in the full-size build), it advances to 0x0000.
- R8: A `rx_start` of 0x0000 disables the receive-start wrap. A `rx_start` above `MEM_LAST` acts as `MEM_LAST`+1, so wrapping happens only at `MEM_LAST`.
- R9: If a pointer load and an access to the same pointer happen in one cycle, the access uses the old pointer and the pointer takes the loaded value.
- R10: If `rd_stb` and `wr_stb` are both high, only the write takes place. `rptr` and `rd_byte` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_rptr | input | 1 | Load read pointer from `ptr_val` |
| ld_wptr | input | 1 | Load write pointer from `ptr_val` |
| ptr_val | input | 15 | Pointer load value |
| rd_stb | input | 1 | Read one byte through the window |
| wr_stb | input | 1 | Write one byte through the window |
| wr_byte | input | 8 | Write data |
| rd_byte | output | 8 | Read data, valid one clock after `rd_stb` |
| rx_start | input | 15 | First address of the receive area |
| rptr | output | 15 | Current read pointer |
| wptr | output | 15 | Current write pointer |

## Verification
If a pointer's next-value logic is wrong, the error shows on `rptr` or `wptr` at the very next edge after the access. It then shifts every later byte that `rd_byte` returns. A wrong boundary decision shows only when the pointer reaches the byte below `rx_start` or reaches `MEM_LAST`. For that reason, the bench walks each pointer across both boundaries for several `rx_start` values, including zero and values beyond the end of memory. A corrupted SRAM word or a misrouted write appears on `rd_byte` one clock after the read of that address, which is caught by write-then-read-back sweeps.

// File: rtl/bufwin_port.sv
module bufwin_port #(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter logic [AW-1:0] MEM_LAST = 15'h0FFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_rptr,
  input  logic          ld_wptr,
  input  logic [AW-1:0] ptr_val,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [DW-1:0] wr_byte,
  output logic [DW-1:0] rd_byte,
  input  logic [AW-1:0] rx_start,
  output logic [AW-1:0] rptr,
  output logic [AW-1:0] wptr
);
  localparam int DEPTH = int'(MEM_LAST) + 1;
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] TOP1 = {1'b0, MEM_LAST} + 1'b1;

  logic [DW-1:0] mem [DEPTH];

  wire do_wr = wr_stb;
  wire do_rd = rd_stb & ~wr_stb;

  wire [AW:0] rx_ext = {1'b0, rx_start};
  wire [AW:0] rx_eff = (rx_ext > TOP1) ? TOP1 : rx_ext;
  wire        has_bnd = (rx_eff != '0);
  wire [AW:0] bnd = rx_eff - 1'b1;

  logic [AW-1:0] rptr_nx, wptr_nx;

  always_comb begin
    if (has_bnd && {1'b0, rptr} == bnd) rptr_nx = '0;
    else if (rptr == MEM_LAST)          rptr_nx = '0;
    else                                rptr_nx = rptr + 1'b1;
  end

  always_comb begin
    if (has_bnd && {1'b0, wptr} == bnd) wptr_nx = '0;
    else if (wptr == MEM_LAST)          wptr_nx = '0;
    else                                wptr_nx = wptr + 1'b1;
  end

  wire r_in = (rptr <= MEM_LAST);
  wire w_in = (wptr <= MEM_LAST);
  wire [IW-1:0] r_idx = rptr[IW-1:0];
  wire [IW-1:0] w_idx = wptr[IW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr    <= '0;
      wptr    <= '0;
      rd_byte <= '0;
    end else begin
      if (ld_rptr)    rptr <= ptr_val;
      else if (do_rd) rptr <= rptr_nx;
      if (ld_wptr)    wptr <= ptr_val;
      else if (do_wr) wptr <= wptr_nx;
      if (do_rd)      rd_byte <= r_in ? mem[r_idx] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr && w_in) mem[w_idx] <= wr_byte;
  end
endmodule

// File: rtl/bufwin_port_chk.sv
module bufwin_port_chk #(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter logic [AW-1:0] MEM_LAST = 15'h0FFF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ld_rptr,
  input logic          ld_wptr,
  input logic [AW-1:0] ptr_val,
  input logic          rd_stb,
  input logic          wr_stb,
  input logic [DW-1:0] wr_byte,
  input logic [DW-1:0] rd_byte,
  input logic [AW-1:0] rx_start,
  input logic [AW-1:0] rptr,
  input logic [AW-1:0] wptr
);
  assert_rload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rptr |=> rptr == $past(ptr_val));
  assert_wload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wptr |=> wptr == $past(ptr_val));
  assert_wptr_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !ld_wptr) |=> $stable(wptr));
  assert_rptr_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rd_stb && !wr_stb) && !ld_rptr) |=> $stable(rptr));
  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && !wr_stb) |=> $stable(rd_byte));
  assert_end_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !ld_wptr && wptr == MEM_LAST) |=> wptr == '0);
  assert_both_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && wr_stb && !ld_rptr) |=> $stable(rptr) && $stable(rd_byte));
endmodule

bind bufwin_port bufwin_port_chk #(.AW(AW), .DW(DW), .MEM_LAST(MEM_LAST)) chk_i (
  .clk(clk), .rst_n(rst_n), .ld_rptr(ld_rptr), .ld_wptr(ld_wptr),
  .ptr_val(ptr_val), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_byte(wr_byte),
  .rd_byte(rd_byte), .rx_start(rx_start), .rptr(rptr), .wptr(wptr)
);

// File: tb/bufwin_port_tb.sv
module bufwin_port_tb_top;
  localparam logic [14:0] LAST = 15'h5FFF;
  logic clk = 0, rst_n = 0;
  logic ld_rptr = 0, ld_wptr = 0, rd_stb = 0, wr_stb = 0;
  logic [14:0] ptr_val = '0, rx_start = '0;
  logic [7:0] wr_byte = '0;
  logic [7:0] rd_byte;
  logic [14:0] rptr, wptr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bufwin_port #(.AW(15), .DW(8), .MEM_LAST(LAST)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_rptr(ld_rptr), .ld_wptr(ld_wptr),
    .ptr_val(ptr_val), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_byte(wr_byte),
    .rd_byte(rd_byte), .rx_start(rx_start), .rptr(rptr), .wptr(wptr));

  function automatic logic [14:0] exp_next(input logic [14:0] p, input logic [14:0] rx);
    int eff = (int'(rx) > int'(LAST) + 1) ? int'(LAST) + 1 : int'(rx);
    if (eff != 0 && int'(p) == eff - 1) return '0;
    if (p == LAST) return '0;
    return p + 15'd1;
  endfunction

  function automatic logic [7:0] pat(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc;
    @(posedge clk); #1;
    ld_rptr = 0; ld_wptr = 0; rd_stb = 0; wr_stb = 0;
  endtask

  task automatic load_r(input logic [14:0] v);
    ld_rptr = 1; ptr_val = v; cyc();
  endtask
  task automatic load_w(input logic [14:0] v);
    ld_wptr = 1; ptr_val = v; cyc();
  endtask
  task automatic wr(input logic [7:0] d);
    wr_stb = 1; wr_byte = d; cyc();
  endtask
  task automatic rd;
    rd_stb = 1; cyc();
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [14:0] ew, er, r0, w0;
    logic [14:0] rxs [7];
    rxs[0] = 15'h0000; rxs[1] = 15'h0001; rxs[2] = 15'h0040; rxs[3] = 15'h2000;
    rxs[4] = 15'h5FFF; rxs[5] = 15'h6000; rxs[6] = 15'h7FFF;
    @(posedge clk); #1; cyc(); rst_n = 1;
    chk("R1 rptr", rptr, 0); chk("R1 wptr", wptr, 0); chk("R1 rd_byte", rd_byte, 0);

    rx_start = 15'h6000;
    load_r(15'h5402); chk("R2 rptr load", rptr, 15'h5402);
    rd; chk("R3 rptr step", rptr, 15'h5403); chk("R3 wptr kept", wptr, 0);
    load_w(15'h0007); chk("R2 wptr load", wptr, 15'h0007);
    wr(8'hA3); chk("R4 wptr step", wptr, 15'h0008); chk("R4 rptr kept", rptr, 15'h5403);
    load_r(15'h0007); rd; chk("R3 data", rd_byte, 8'hA3);
    repeat (3) cyc(); chk("R3 data hold", rd_byte, 8'hA3);

    // R5 fill and read back a window
    load_w(15'h0100);
    for (int i = 0; i < 256; i++) begin
      wr(pat(15'h0100 + 15'(i)));
      chk("R5 wptr +1", wptr, 15'h0101 + 15'(i));
    end
    load_r(15'h0100);
    for (int i = 0; i < 256; i++) begin
      rd; chk("R3 readback", rd_byte, pat(15'h0100 + 15'(i)));
      chk("R5 rptr +1", rptr, 15'h0101 + 15'(i));
    end

    // R6 R7 R8 boundary walks for several receive starts
    foreach (rxs[k]) begin
      int eff;
      rx_start = rxs[k];
      eff = (int'(rxs[k]) > int'(LAST) + 1) ? int'(LAST) + 1 : int'(rxs[k]);
      w0 = (eff >= 3) ? 15'(eff - 3) : 15'h5FFD;
      load_w(w0); ew = w0;
      for (int j = 0; j < 6; j++) begin
        wr(pat(ew)); ew = exp_next(ew, rxs[k]);
        chk((eff == 0 || eff > int'(LAST)) ? "R8 wptr walk" : "R6 wptr walk", wptr, ew);
      end
      r0 = w0; load_r(r0); er = r0;
      for (int j = 0; j < 6; j++) begin
        rd; chk("R3 walk data", rd_byte, pat(er)); er = exp_next(er, rxs[k]);
        chk((eff == 0 || eff > int'(LAST)) ? "R7 rptr walk" : "R6 rptr walk", rptr, er);
      end
    end

    // R6 priority: boundary below end; R7 plain end
    rx_start = 15'h0010; load_w(15'h000F); wr(8'h11); chk("R6 wrap at rx-1", wptr, 0);
    load_w(LAST); wr(8'h22); chk("R7 wrap at end", wptr, 0);
    // R2 load into receive area then continue
    load_w(15'h0020); wr(8'h33); chk("R2 inside rx area", wptr, 15'h0021);

    // R9 load and access together
    rx_start = 15'h6000;
    load_w(15'h0200); wr(8'h44);
    ld_wptr = 1; ptr_val = 15'h0300; wr_stb = 1; wr_byte = 8'h55; cyc();
    chk("R9 wptr load wins", wptr, 15'h0300);
    load_r(15'h0201); rd; chk("R9 write used old ptr", rd_byte, 8'h55);
    load_r(15'h0200);
    ld_rptr = 1; ptr_val = 15'h0400; rd_stb = 1; cyc();
    chk("R9 rptr load wins", rptr, 15'h0400); chk("R9 read used old ptr", rd_byte, 8'h44);

    // R10 both strobes
    load_r(15'h0500); load_w(15'h0600);
    rd_stb = 1; wr_stb = 1; wr_byte = 8'h66; cyc();
    chk("R10 rptr kept", rptr, 15'h0500); chk("R10 rd_byte kept", rd_byte, 8'h44);
    chk("R10 write done", wptr, 15'h0601);
    load_r(15'h0600); rd; chk("R10 written data", rd_byte, 8'h66);

    // R1 reset again
    rst_n = 0; cyc(); rst_n = 1;
    chk("R1 rptr after reset", rptr, 0); chk("R1 wptr after reset", wptr, 0);
    chk("R1 rd_byte after reset", rd_byte, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule